// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs one instruction to completion on every rising clock edge. Each instruction is fetched from the word at the current program counter, its registers are read, and the ALU produces a result, a data address or a branch comparison. The result is then written back, and the program counter moves on, all in the same cycle. The supported set is small: word load and word store, the register-register operations add, subtract, AND, OR and signed set-on-less-than, branch-if-equal, and an absolute jump.

Instruction and data memories sit outside the core as separate word arrays that the surrounding environment fills. The core presents the program counter as the fetch address and expects the instruction word back combinationally. It presents the data address, store data and a write strobe, and expects the read word back combinationally. There is no handshake on either memory side: a single-cycle machine cannot absorb a wait, so both memories must answer within the cycle. Decode runs in two levels. The main decoder turns the opcode into control signals and a 2-bit operation class. A second decoder combines that class with the function field to give a 3-bit ALU code, and the top bit of that code inverts operand B.

Top module: `m32_core`

## Requirements
- R1: While reset is high at a rising edge (synchronous, active high), the program counter and every register become zero and no data write is issued; the first instruction after reset is fetched from address 0.
- R2: Opcode 0 with function 100000, 100010, 100100 or 100101 writes rs+rs2, rs−rt, rs AND rt or rs OR rt (rs in bits 25:21, rt in 20:16) into the register named by bits 15:11, with 32-bit wraparound; the function field is bits 5:0.
- R3: Opcode 0 with function 101010 writes 1 into rd when rs is less than rt as signed two's-complement numbers, else 0.
- R4: Opcode 35 reads the data word at rs plus the sign-extended 16-bit field in bits 15:0 and writes it into rt.
- R5: Opcode 43 drives the write strobe for one cycle, with address rs plus sign-extended bits 15:0 and data rt; no other opcode drives the strobe.
- R6: Opcode 4 with rs equal to rt sets the next PC to PC+4 plus the sign-extended bits 15:0 shifted left by two; when they differ the next PC is PC+4.
- R7: Opcode 2 sets the next PC to PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R8: Register 0 always reads as zero; a write aimed at it leaves it zero.
- R9: An opcode other than 0, 2, 4, 35 and 43 writes no register and no memory, and advances the PC by 4.
- R10: Every instruction that is not a branch or a jump advances the PC by 4 in the next cycle, one instruction per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr, returned in the same cycle |
| dmem_addr | output | 32 | Byte address for the data access (ALU result) |
| dmem_wdata | output | 32 | Store data (value of rt) |
| dmem_we | output | 1 | Data write strobe, high only for a store outside reset |
| dmem_rdata | input | 32 | Data word at dmem_addr, returned in the same cycle |

## Verification
A directed program loads a negative and a positive word. It then compares them both ways with set-on-less-than, so a signed compare is told apart from an unsigned one. It also writes to register 0 and stores it, and follows one branch that falls through, one taken forward branch, a jump over a store, and an undefined opcode. Random programs then mix all instruction kinds over a small register set, so results feed later operands, loads and stores. Small signed offsets send branches both forward and backward, and the jumps land inside the program. Every cycle the fetch address and the store strobe, address and data are compared with an instruction-level model kept in the bench. A wrong result in any register therefore shows up when that register is next stored.

// File: rtl/m32_pkg.sv
package m32_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RR  = 6'd0;
  localparam logic [5:0] OP_JMP = 6'd2;
  localparam logic [5:0] OP_BEQ = 6'd4;
  localparam logic [5:0] OP_LDW = 6'd35;
  localparam logic [5:0] OP_STW = 6'd43;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_RR  = 2'b10
  } alu_cls_e;

  typedef enum logic [2:0] {
    AOP_AND = 3'b000,
    AOP_OR  = 3'b001,
    AOP_ADD = 3'b010,
    AOP_SUB = 3'b110,
    AOP_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic reg_we;
    logic dst_is_rd;
    logic src_imm;
    logic mem_we;
    logic load;
    logic branch;
    logic jump;
  } ctrl_t;
endpackage

// File: rtl/m32_regfile.sv
module m32_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R2 / R4: a write to a nonzero register is held there afterwards
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

  // R8: port reads of register 0 stay zero even right after a write aimed at it
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0 && ra1 == '0) |-> ##1 (ra1 != '0 || rd1 == '0));
endmodule

// File: rtl/m32_decode.sv
module m32_decode
  import m32_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    aop
);
  alu_cls_e cls;

  always_comb begin
    ctrl = '0;
    cls  = CLS_MEM;
    case (opcode)
      OP_RR: begin
        ctrl.reg_we    = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        cls            = CLS_RR;
      end
      OP_LDW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.load    = 1'b1;
      end
      OP_STW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        cls         = CLS_BR;
      end
      OP_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (cls)
      CLS_MEM: aop = AOP_ADD;
      CLS_BR:  aop = AOP_SUB;
      default: begin
        case (funct)
          FN_SUB:  aop = AOP_SUB;
          FN_AND:  aop = AOP_AND;
          FN_OR:   aop = AOP_OR;
          FN_SLT:  aop = AOP_SLT;
          default: aop = AOP_ADD;
        endcase
      end
    endcase
  end

  // R9: an opcode outside the known set produces no side effect
  always_comb begin
    if (!(opcode inside {OP_RR, OP_JMP, OP_BEQ, OP_LDW, OP_STW}))
      p_undef_nop_r9: assert (!ctrl.reg_we && !ctrl.mem_we && !ctrl.branch && !ctrl.jump);
  end
endmodule

// File: rtl/m32_alu.sv
module m32_alu
  import m32_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] bx;
  logic [W-1:0] sum;
  logic         ovf;
  logic         lt;

  assign bx  = op[2] ? ~b : b;
  assign sum = a + bx + {{(W-1){1'b0}}, op[2]};
  assign ovf = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
  assign lt  = sum[W-1] ^ ovf;

  always_comb begin
    case (op[1:0])
      2'b00:   y = a & bx;
      2'b01:   y = a | bx;
      2'b10:   y = sum;
      default: y = {{(W-1){1'b0}}, lt};
    endcase
  end

  assign zero = (y == '0);

  // R3: set-on-less-than agrees with a signed comparison
  always_comb begin
    if (op == AOP_SLT)
      p_slt_signed_r3: assert (y == {{(W-1){1'b0}}, ($signed(a) < $signed(b))});
  end
endmodule

// File: rtl/m32_core.sv
module m32_core
  import m32_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic [XLEN-1:0] wb_data;
  logic            alu_zero;
  logic [AW-1:0]   dst;
  ctrl_t           ctrl;
  alu_op_e         aop;

  assign imm_sx = {{16{imem_data[15]}}, imem_data[15:0]};

  m32_decode u_dec (
    .opcode (imem_data[31:26]),
    .funct  (imem_data[5:0]),
    .ctrl   (ctrl),
    .aop    (aop)
  );

  assign dst     = ctrl.dst_is_rd ? imem_data[15:11] : imem_data[20:16];
  assign wb_data = ctrl.load ? dmem_rdata : alu_y;

  m32_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (ctrl.reg_we),
    .wa  (dst),
    .wd  (wb_data),
    .ra1 (imem_data[25:21]),
    .ra2 (imem_data[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_sx : rt_val;

  m32_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (aop),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign pc_plus4   = pc + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc[31:28], imem_data[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                      pc_next = jmp_target;
    else if (ctrl.branch && alu_zero)   pc_next = br_target;
    else                                pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & ~rst;

  // R1: reset brings the PC to zero
  p_pc_reset_r1: assert property (@(posedge clk) rst |=> pc == '0);

  // R10: straight-line instructions step the PC by one word
  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.branch && !ctrl.jump) |=> pc == $past(pc) + 32'd4);

  // R7: jump target is the bit concatenation of old PC top and the field
  p_jump_form_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> pc == {$past(pc[31:28]), $past(imem_data[25:0]), 2'b00});
endmodule

// File: tb/m32_core_tb.sv
module m32_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW         = 8;
  localparam int MWORDS     = 1 << IW;
  localparam int NPROG      = 6;
  localparam int NCYC       = 1500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  m32_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] imem [MWORDS];
  logic [31:0] dmem [MWORDS];
  logic [31:0] dimg [MWORDS];
  logic        load_now = 1'b0;

  assign imem_data  = imem[imem_addr[IW+1:2]];
  assign dmem_rdata = dmem[dmem_addr[IW+1:2]];

  always @(posedge clk) begin
    if (load_now) begin
      for (int i = 0; i < MWORDS; i++) dmem[i] <= dimg[i];
    end else if (dmem_we) begin
      dmem[dmem_addr[IW+1:2]] <= dmem_wdata;
    end
  end

  // instruction-level model
  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [MWORDS];
  string       m_src [32];
  string       pc_tag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [5:0] FNS [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
  localparam logic [5:0] BADOPS [4] = '{6'd1, 6'd3, 6'd9, 6'd63};

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic bit known_op(logic [5:0] op);
    return (op == 6'd0 || op == 6'd2 || op == 6'd4 || op == 6'd35 || op == 6'd43);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h (pc=%h)", tag, what, act, exp, m_pc);
    end
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, v, addr;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    ins  = imem[m_pc[IW+1:2]];
    op   = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    a    = m_reg[rs]; b = m_reg[rt];
    addr = a + sext(ins[15:0]);
    case (op)
      6'd0: begin
        case (fn)
          6'b100010: v = a - b;
          6'b100100: v = a & b;
          6'b100101: v = a | b;
          6'b101010: v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default:   v = a + b;
        endcase
        if (rd != 5'd0) begin
          m_reg[rd] = v;
          m_src[rd] = (fn == 6'b101010) ? "R3" : "R2";
        end
        m_pc = m_pc + 32'd4; pc_tag = "R10";
      end
      6'd35: begin
        if (rt != 5'd0) begin
          m_reg[rt] = m_mem[addr[IW+1:2]];
          m_src[rt] = "R4";
        end
        m_pc = m_pc + 32'd4; pc_tag = "R10";
      end
      6'd43: begin
        m_mem[addr[IW+1:2]] = b;
        m_pc = m_pc + 32'd4; pc_tag = "R10";
      end
      6'd4: begin
        if (a == b) m_pc = m_pc + 32'd4 + {sext(ins[15:0])[29:0], 2'b00};
        else        m_pc = m_pc + 32'd4;
        pc_tag = "R6";
      end
      6'd2: begin
        m_pc = {m_pc[31:28], ins[25:0], 2'b00};
        pc_tag = "R7";
      end
      default: begin
        m_pc = m_pc + 32'd4; pc_tag = "R9";
      end
    endcase
  endtask

  task automatic check_cycle();
    logic [31:0] ins;
    logic [5:0]  op;
    logic [4:0]  rs, rt;
    ins = imem[m_pc[IW+1:2]];
    op  = ins[31:26]; rs = ins[25:21]; rt = ins[20:16];
    chk(pc_tag, "fetch address", imem_addr, m_pc);
    if (op == 6'd43) begin
      chk("R5", "store strobe", {31'd0, dmem_we}, 32'd1);
      chk("R5", "store address", dmem_addr, m_reg[rs] + sext(ins[15:0]));
      chk(m_src[rt], "store data", dmem_wdata, m_reg[rt]);
    end else begin
      chk(known_op(op) ? "R5" : "R9", "no store strobe", {31'd0, dmem_we}, 32'd0);
    end
    model_step();
  endtask

  task automatic run_prog(int ncyc);
    @(negedge clk);
    rst = 1'b1; load_now = 1'b1;
    @(negedge clk);
    load_now = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "PC held at zero in reset", imem_addr, 32'd0);
    chk("R1", "no store in reset", {31'd0, dmem_we}, 32'd0);
    m_pc = 32'd0;
    for (int i = 0; i < 32; i++) begin m_reg[i] = 32'd0; m_src[i] = "R1"; end
    m_src[0] = "R8";
    for (int i = 0; i < MWORDS; i++) m_mem[i] = dimg[i];
    pc_tag = "R1";
    rst = 1'b0;
    #1;
    for (int c = 0; c < ncyc; c++) begin
      check_cycle();
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [4:0] pick_reg();
    if ($urandom % 5 == 0) return 5'd0;
    return 5'($urandom % 8);
  endfunction

  task automatic gen_random();
    for (int i = 0; i < MWORDS; i++) begin
      int k;
      k = $urandom % 100;
      if (k < 40)      imem[i] = enc_r(pick_reg(), pick_reg(), pick_reg(), FNS[$urandom % 5]);
      else if (k < 55) imem[i] = enc_i(6'd35, pick_reg(), pick_reg(), 16'($urandom % 128) - 16'd64);
      else if (k < 70) imem[i] = enc_i(6'd43, pick_reg(), pick_reg(), 16'($urandom % 128) - 16'd64);
      else if (k < 82) imem[i] = enc_i(6'd4, pick_reg(), pick_reg(), 16'($urandom % 16) - 16'd8);
      else if (k < 88) imem[i] = enc_j(26'($urandom % MWORDS));
      else if (k < 93) imem[i] = {BADOPS[$urandom % 4], 26'($urandom)};
      else             imem[i] = enc_r(pick_reg(), pick_reg(), pick_reg(), FNS[$urandom % 5]);
      dimg[i] = $urandom;
      if ($urandom % 4 == 0) dimg[i][31] = 1'b1;
    end
  endtask

  task automatic gen_directed();
    for (int i = 0; i < MWORDS; i++) begin
      imem[i] = {6'h3f, 26'd0};
      dimg[i] = 32'h0;
    end
    dimg[0] = 32'h8000_0005;
    dimg[1] = 32'h0000_0007;
    imem[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);          // R4 load negative
    imem[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);          // R4 load positive
    imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b101010);       // R3 neg < pos -> 1
    imem[3]  = enc_r(5'd2, 5'd1, 5'd4, 6'b101010);       // R3 pos < neg -> 0
    imem[4]  = enc_r(5'd2, 5'd1, 5'd5, 6'b100010);       // R2 sub wraps
    imem[5]  = enc_r(5'd2, 5'd2, 5'd0, 6'b100000);       // R8 write to r0
    imem[6]  = enc_i(6'd43, 5'd0, 5'd0, 16'd8);          // R8 store r0
    imem[7]  = enc_i(6'd43, 5'd0, 5'd3, 16'd12);
    imem[8]  = enc_r(5'd1, 5'd2, 5'd6, 6'b100100);
    imem[9]  = enc_r(5'd1, 5'd2, 5'd7, 6'b100101);
    imem[10] = enc_i(6'd43, 5'd0, 5'd6, 16'd16);
    imem[11] = enc_i(6'd43, 5'd0, 5'd7, 16'd20);
    imem[12] = enc_i(6'd43, 5'd0, 5'd5, 16'd24);
    imem[13] = {6'h3f, 5'd1, 5'd3, 16'hffff};            // R9 undefined opcode
    imem[14] = enc_i(6'd4, 5'd3, 5'd4, 16'd5);           // R6 not taken
    imem[15] = enc_i(6'd4, 5'd2, 5'd2, 16'd2);           // R6 taken to word 18
    imem[16] = enc_i(6'd43, 5'd0, 5'd1, 16'd28);
    imem[17] = enc_i(6'd43, 5'd0, 5'd1, 16'd28);
    imem[18] = enc_j(26'd20);                            // R7 jump to word 20
    imem[19] = enc_i(6'd43, 5'd0, 5'd1, 16'd32);
    imem[20] = enc_i(6'd43, 5'd0, 5'd3, 16'd36);
    imem[21] = enc_i(6'd4, 5'd0, 5'd0, 16'hffff);        // R6 backward, self loop
  endtask

  initial begin
    void'($urandom(32'd20240611));
    gen_directed();
    run_prog(40);
    for (int p = 0; p < NPROG; p++) begin
      gen_random();
      run_prog(NCYC);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule